// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block is the byte-wide arithmetic and logic datapath of a small accumulator machine. It takes the accumulator value and a second operand, applies the operation selected by a 4-bit opcode and returns the 8-bit result combinationally. The accumulator register, register file, memory access and instruction decode sit outside the block. It keeps its own status register with five meaningful flags: sign, zero, half-carry, even parity and carry. This register updates on the clock edge only when the flag write enable is high.

The stored carry feeds the carry-in and borrow-in operations. Software can therefore build 16-bit add or subtract from two byte operations: the low bytes first, then the high bytes with carry. A compare gives the flags of a subtraction and passes the accumulator through unchanged. Complement inverts the accumulator. The four rotates change only the carry flag.

Opcode encoding: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 rotate left circular, 10 rotate right circular, 11 rotate left through carry, 12 rotate right through carry. Codes 13 to 15 are unused.

Top module: `acc_alu`

## Requirements
- R1: The flag register reads sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R2: Add (0) gives a+b and add with carry (1) gives a+b+CY, both modulo 256. CY becomes the carry out of bit 7. The half-carry becomes the carry out of the low nibble sum, including the carry-in.
- R3: Subtract (2) gives a-b and subtract with borrow (3) gives a-b-CY, both modulo 256. CY becomes 1 exactly when a borrow occurs. The half-carry is the carry out of bit 3 of the sum a + ~b + (1 - borrow-in).
- R4: Compare (4) updates every flag as subtract would, while the result output equals the accumulator input.
- R5: For arithmetic and logic operations, sign is result bit 7 and zero is set when the 8-bit result is 0. Parity is set when the result holds an even number of 1 bits; for compare the result used is the difference.
- R6: AND (5), OR (6) and XOR (7) give the bitwise result and clear both carry and half-carry.
- R7: Complement (8) gives the bitwise inverse of the accumulator and leaves all flags unchanged.
- R8: Rotate left (9) and rotate right (10) move the bit that wraps around into CY. Rotate through carry left (11) and right (12) move the old CY into the vacated bit and the bit shifted out into CY. Rotates change no flag other than CY.
- R9: Flags change only at a clock edge where the write enable is 1; otherwise they hold.
- R10: Reset, active low, clears the flag register to 0x00.
- R11: Unused opcodes 13 to 15 pass the accumulator to the result and leave the flags unchanged.
- R12: An add of the low bytes followed by an add with carry of the high bytes gives the 16-bit sum. A subtract followed by a subtract with borrow gives the 16-bit difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Flag register |

## Verification
The assertions check four things on every cycle. Flags hold without a write enable, and complement and the unused codes never touch them. Rotates keep every flag but carry, and logic operations clear both carries. Compare passes the accumulator through, and the zero flag tracks the result that was written. Only the bench scenarios show the arithmetic values: carry, borrow and half-carry at the nibble and byte boundaries, and parity. They also show the carry-in paths of the rotates and the 16-bit chained add and subtract.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_AC = 4;
    localparam int FL_P  = 2;
    localparam int FL_CY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_CMA = 4'd8,
        OP_RLC = 4'd9,
        OP_RRC = 4'd10,
        OP_RAL = 4'd11,
        OP_RAR = 4'd12,
        OP_U13 = 4'd13,
        OP_U14 = 4'd14,
        OP_U15 = 4'd15
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_half_o,
    output logic         c_out_o
);
    localparam int LO_W = W / 2;
    localparam int HI_W = W - LO_W;

    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    always_comb begin
        lo_sum   = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
        hi_sum   = {1'b0, a_i[W-1:LO_W]} + {1'b0, b_i[W-1:LO_W]} + {{HI_W{1'b0}}, lo_sum[LO_W]};
        sum_o    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        c_half_o = lo_sum[LO_W];
        c_out_o  = hi_sum[HI_W];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; end
            OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
            OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
            OP_CMA: res_o = ~a_i;
            OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
            OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
            OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
            OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        flags_o
);
    op_e    op;
    flags_t fl_d, fl_q;

    logic              is_sub, is_arith, is_logic, is_rot;
    logic [DATA_W-1:0] b_eff, sum, bit_res, res_d;
    logic              add_cin, c_half, c_out, bit_cy;

    assign op = op_e'(op_i);

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        is_arith = (op == OP_ADD) || (op == OP_ADC) || is_sub;
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        is_rot   = (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);
        b_eff    = is_sub ? ~opnd_i : opnd_i;
        unique case (op)
            OP_ADC:  add_cin = fl_q.cy;
            OP_SUB,
            OP_CMP:  add_cin = 1'b1;
            OP_SBB:  add_cin = ~fl_q.cy;
            default: add_cin = 1'b0;
        endcase
    end

    acc_alu_adder #(.W(DATA_W)) u_adder (
        .a_i      (acc_i),
        .b_i      (b_eff),
        .cin_i    (add_cin),
        .sum_o    (sum),
        .c_half_o (c_half),
        .c_out_o  (c_out)
    );

    acc_alu_bitops #(.W(DATA_W)) u_bitops (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (fl_q.cy),
        .res_o (bit_res),
        .cy_o  (bit_cy)
    );

    // Next-state: flag values and the result
    always_comb begin
        fl_d  = fl_q;
        res_d = is_arith ? sum : bit_res;
        if (flag_we_i) begin
            if (is_arith || is_logic) begin
                fl_d.s  = res_d[DATA_W-1];
                fl_d.z  = (res_d == '0);
                fl_d.p  = ~^res_d;
                fl_d.ac = is_arith ? c_half : 1'b0;
                fl_d.cy = is_arith ? (c_out ^ is_sub) : 1'b0;
            end else if (is_rot) begin
                fl_d.cy = bit_cy;
            end
        end
        if (op == OP_CMP) res_d = acc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign result_o = res_d;

    always_comb begin
        flags_o        = '0;
        flags_o[FL_S]  = fl_q.s;
        flags_o[FL_Z]  = fl_q.z;
        flags_o[FL_AC] = fl_q.ac;
        flags_o[FL_P]  = fl_q.p;
        flags_o[FL_CY] = fl_q.cy;
    end

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o)); // R9
    AST_CMA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8) |=> $stable(flags_o)); // R7
    AST_UNUSED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd13) |=> $stable(flags_o)); // R11
    AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd9 && op_i <= 4'd12) |=> (flags_o[7:1] == $past(flags_o[7:1]))); // R8
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i >= 4'd5 && op_i <= 4'd7) |=> (!flags_o[0] && !flags_o[4])); // R6
    AST_CMP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4) |-> (result_o == acc_i)); // R4
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i <= 4'd3) |=> (flags_o[6] == ($past(result_o) == 8'h00))); // R5
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic       flag_we_i = 1'b0;
    logic [7:0] result_o;
    logic [7:0] flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .acc_i     (acc_i),
        .opnd_i    (opnd_i),
        .flag_we_i (flag_we_i),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    // {op, a, b, carry before}
    localparam logic [20:0] VECS [20] = '{
        {4'd0,  8'h3A, 8'hC6, 1'b0},
        {4'd0,  8'h0F, 8'h01, 1'b0},
        {4'd0,  8'h80, 8'h80, 1'b1},
        {4'd1,  8'hFF, 8'h00, 1'b1},
        {4'd1,  8'h07, 8'h08, 1'b1},
        {4'd2,  8'h10, 8'h01, 1'b0},
        {4'd2,  8'h05, 8'h05, 1'b1},
        {4'd3,  8'h00, 8'h00, 1'b1},
        {4'd3,  8'h50, 8'h20, 1'b1},
        {4'd4,  8'h20, 8'h30, 1'b0},
        {4'd4,  8'h44, 8'h44, 1'b1},
        {4'd5,  8'hF0, 8'h3C, 1'b1},
        {4'd6,  8'h81, 8'h02, 1'b1},
        {4'd7,  8'hAA, 8'hAA, 1'b1},
        {4'd8,  8'h5A, 8'h00, 1'b1},
        {4'd9,  8'h81, 8'h00, 1'b0},
        {4'd10, 8'h01, 8'h00, 1'b0},
        {4'd11, 8'h80, 8'h00, 1'b0},
        {4'd11, 8'h00, 8'h00, 1'b1},
        {4'd12, 8'h02, 8'h00, 1'b1}
    };

    function automatic logic [7:0] pack_fl(logic s, logic z, logic ac, logic p, logic cy);
        return {s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
    endfunction

    // Independent model: returns {result, flags}
    function automatic logic [15:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] fl);
        int c, full, lo;
        logic [7:0] r, d;
        logic cy;
        c = fl[0] ? 1 : 0;
        case (op)
            4'd0, 4'd1: begin
                if (op == 4'd0) c = 0;
                full = int'(a) + int'(b) + c;
                lo = int'(a % 16) + int'(b % 16) + c;
                r = full[7:0];
                return {r, pack_fl(r[7], r == 0, lo > 15, ($countones(r) % 2) == 0, full > 255)};
            end
            4'd2, 4'd3, 4'd4: begin
                if (op != 4'd3) c = 0;
                full = int'(a) - int'(b) - c;
                lo = int'(a % 16) + int'((~b) % 16) + (1 - c);
                d = full[7:0];
                r = (op == 4'd4) ? a : d;
                return {r, pack_fl(d[7], d == 0, lo > 15, ($countones(d) % 2) == 0, full < 0)};
            end
            4'd5, 4'd6, 4'd7: begin
                r = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) : (a ^ b);
                return {r, pack_fl(r[7], r == 0, 1'b0, ($countones(r) % 2) == 0, 1'b0)};
            end
            4'd8: return {~a, fl};
            4'd9:  begin r = (a << 1) | (a >> 7); cy = a[7]; return {r, fl[7:1], cy}; end
            4'd10: begin r = (a >> 1) | (a << 7); cy = a[0]; return {r, fl[7:1], cy}; end
            4'd11: begin r = (a << 1) | 8'(c);     cy = a[7]; return {r, fl[7:1], cy}; end
            4'd12: begin r = (a >> 1) | (8'(c) << 7); cy = a[0]; return {r, fl[7:1], cy}; end
            default: return {a, fl};
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation; returns result (sampled before edge) and flags after edge
    task automatic run_op(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic we,
                          output logic [7:0] res, output logic [7:0] fl);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; flag_we_i = we;
        #1 res = result_o;
        @(negedge clk);
        fl = flags_o;
        flag_we_i = 1'b0;
        op_i = 4'd13;
    endtask

    task automatic set_carry(logic c, output logic [7:0] fl);
        logic [7:0] r;
        if (c) run_op(4'd2, 8'h00, 8'h01, 1'b1, r, fl);
        else   run_op(4'd5, 8'h00, 8'h00, 1'b1, r, fl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, fl, fl0;
        logic [15:0] e;
        op_i = 4'd13;
        repeat (3) @(negedge clk);
        // R10: reset clears flags
        check(flags_o == 8'h00, "R10", {8'h0, flags_o}, 16'h0000);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R1
        foreach (VECS[i]) begin
            set_carry(VECS[i][0], fl0);
            e = model(VECS[i][20:17], VECS[i][16:9], VECS[i][8:1], fl0);
            run_op(VECS[i][20:17], VECS[i][16:9], VECS[i][8:1], 1'b1, r, fl);
            check(r == e[15:8], "R2/R3/R4/R6/R7/R8 result", {8'h0, r}, {8'h0, e[15:8]});
            check(fl == e[7:0], "R1/R5 flags", {8'h0, fl}, {8'h0, e[7:0]});
        end

        // R1: specific layout check: 0x00 - 0x01 -> FF, S P CY set
        run_op(4'd2, 8'h00, 8'h01, 1'b1, r, fl);
        check(fl == 8'h85, "R1 layout", {8'h0, fl}, 16'h0085);
        // R5: zero flag from 0x80+0x80
        run_op(4'd0, 8'h80, 8'h80, 1'b1, r, fl);
        check(fl == 8'h45, "R5 zero/parity", {8'h0, fl}, 16'h0045);
        // R2: half carry 0x0F+0x01 = 0x10
        run_op(4'd0, 8'h0F, 8'h01, 1'b1, r, fl);
        check(r == 8'h10 && fl == 8'h10, "R2 half-carry", {r, fl}, 16'h1010);

        // R9: write enable low holds flags
        set_carry(1'b1, fl0);
        run_op(4'd0, 8'h00, 8'h00, 1'b0, r, fl);
        check(fl == fl0, "R9 hold", {8'h0, fl}, {8'h0, fl0});
        check(r == 8'h00, "R9 result still combinational", {8'h0, r}, 16'h0000);

        // R11: unused opcodes
        for (int k = 13; k < 16; k++) begin
            run_op(4'(k), 8'hC3, 8'h11, 1'b1, r, fl);
            check(r == 8'hC3 && fl == fl0, "R11 unused opcode", {r, fl}, {8'hC3, fl0});
        end

        // R7: complement does not alter flags
        run_op(4'd8, 8'h00, 8'h00, 1'b1, r, fl);
        check(r == 8'hFF && fl == fl0, "R7 complement", {r, fl}, {8'hFF, fl0});

        // R12: 0x12FF + 0x0101 = 0x1400
        run_op(4'd0, 8'hFF, 8'h01, 1'b1, r, fl);
        check(r == 8'h00 && fl[0], "R12 low add", {r, fl}, 16'h0001);
        run_op(4'd1, 8'h12, 8'h01, 1'b1, r, fl);
        check(r == 8'h14 && !fl[0], "R12 high adc", {r, fl}, 16'h1400);
        // R12: 0x1400 - 0x0001 = 0x13FF
        run_op(4'd2, 8'h00, 8'h01, 1'b1, r, fl);
        check(r == 8'hFF && fl[0], "R12 low sub", {r, fl}, 16'hFF01);
        run_op(4'd3, 8'h14, 8'h00, 1'b1, r, fl);
        check(r == 8'h13 && !fl[0], "R12 high sbb", {r, fl}, 16'h1300);

        // R10: reset in mid-run
        set_carry(1'b1, fl0);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(flags_o == 8'h00, "R10 async reset", {8'h0, flags_o}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule